// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit processor core that carries each instruction through a variable number of clock steps on one shared datapath. One ALU computes the PC increment, the branch target, the effective address and the arithmetic result, each in a different step. A finite-state controller decides, per step, which registers capture and which operands feed the ALU. The core keeps a program counter, an instruction latch, a memory-data latch, two operand latches, an ALU result latch and a 32-entry register file.

The core drives a single memory that holds both code and data. It does this through an address bus, a write-data bus, a write strobe and a read-data bus. Read data must be valid in the same cycle as the address it answers, and a write takes effect at the clock edge. Instructions take different numbers of steps: two for an unrecognised opcode, three for branch and jump, four for register arithmetic and store, and five for load. The branch target is computed during decode for every instruction, whether or not it turns out to be a branch.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, the PC is 0, the controller is in the fetch step and every register-file entry reads 0. In the first cycle after release, `mem_addr` is 0 and `mem_we` is 0.
- R2: In the fetch step, `mem_addr` equals the PC, the instruction latch captures `mem_rdata`, and the PC advances by 4. The decode step always follows.
- R3: The opcode is instruction bits 31:26. Its values are 0x00 register arithmetic, 0x23 load, 0x2B store, 0x04 branch-if-equal and 0x02 jump. Counting fetch, branch and jump take 3 cycles, arithmetic and store take 4, load takes 5, and any other opcode takes 2.
- R4: Register arithmetic reads rs (bits 25:21) and rt (bits 20:16) and writes rd (bits 15:11). The funct field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Any other funct value writes 0.
- R5: A load forms the address rs + sign-extended bits 15:0. It drives that address with `mem_we` low in its fourth cycle and writes the word read into rt.
- R6: A store drives rs + sign-extended bits 15:0 on `mem_addr` for its fourth cycle only. In that cycle `mem_we` is 1 and `mem_wdata` holds the value of rt.
- R7: A branch compares rs with rt. When they are equal, the next PC is (PC+4) + (sign-extended bits 15:0 shifted left by 2). Otherwise the next PC is PC+4.
- R8: A jump sets the PC to bits 31:28 of PC+4, followed by instruction bits 25:0, followed by two zero bits.
- R9: Register 0 always reads 0. Arithmetic or load results aimed at register 0 are discarded.
- R10: Outside the fourth cycle of a load or store, `mem_addr` carries the current PC (PC+4 once fetch has completed), and `mem_we` is 1 only in a store's fourth cycle.
- R11: An unrecognised opcode changes no register and no memory word. Only the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset: asserted asynchronously, released in step with the clock |
| mem_rdata | input | 32 | Word read at `mem_addr`, valid in the same cycle |
| mem_addr | output | 32 | Byte address for fetch, load and store |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe, one cycle per store |

## Verification
The fetch address appears in the first cycle of each instruction. The decode and execute cycles show PC+4. The load or store address and the store strobe appear in the fourth cycle, and a load's write-back falls in the fifth. A branch or jump redirect shows up as the fetch address of the next instruction, one cycle after its third step. The bench holds an instruction-level model that unfolds each instruction into exactly this per-cycle bus trace. It samples every cycle on the falling clock edge, so a single missing or extra controller step shifts every later address and is caught. Register results are made visible through stores: the data region of memory is compared against the model after each program, and a few directed results are compared against hand-derived constants.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned REG_CNT = 32;
  localparam int unsigned REG_AW  = $clog2(REG_CNT);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EXE_ALU, ST_EXE_ADDR, ST_EXE_BEQ,
    ST_EXE_JMP, ST_ALU_WB, ST_LD_MEM, ST_ST_MEM, ST_LD_WB
  } step_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_FUNCT} alu_op_e;
  typedef enum logic       {SA_PC, SA_REG} src_a_e;
  typedef enum logic [1:0] {SB_REG, SB_FOUR, SB_IMM, SB_BROFF} src_b_e;
  typedef enum logic [1:0] {PS_ALU, PS_LATCH, PS_JUMP} pc_src_e;

  typedef struct packed {
    logic    pc_we;
    logic    pc_cond;
    pc_src_e pc_src;
    logic    ir_we;
    logic    ab_we;
    src_a_e  src_a;
    src_b_e  src_b;
    alu_op_e alu_op;
    logic    res_we;
    logic    mdr_we;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mdr;
    logic    addr_from_res;
    logic    mem_we;
  } ctl_t;

  function automatic logic op_known(input logic [5:0] op);
    return (op == OP_RTYPE) || (op == OP_LOAD) || (op == OP_STORE) ||
           (op == OP_BEQ) || (op == OP_JUMP);
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  input  logic [5:0]   funct_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  logic [W-1:0] sum, diff, fsel;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;

  always_comb begin
    case (funct_i)
      FN_ADD:  fsel = sum;
      FN_SUB:  fsel = diff;
      FN_AND:  fsel = a_i & b_i;
      FN_OR:   fsel = a_i | b_i;
      FN_SLT:  fsel = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: fsel = '0;
    endcase
  end

  always_comb begin
    case (op_i)
      ALU_ADD: y_o = sum;
      ALU_SUB: y_o = diff;
      default: y_o = fsel;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 32,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N); i++) q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = q[ra1_i];
  assign rd2_o = q[ra2_i];

  // R9: entry zero keeps reading zero whatever was written to it
  a_r9_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1_i == '0) |-> (rd1_o == '0));
  a_r9_zero_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wa_i == '0) |=> (q[0] == '0));
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode_i,
  output step_e      step_o,
  output ctl_t       ctl_o
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode_i)
          OP_RTYPE:         step_d = ST_EXE_ALU;
          OP_LOAD, OP_STORE: step_d = ST_EXE_ADDR;
          OP_BEQ:           step_d = ST_EXE_BEQ;
          OP_JUMP:          step_d = ST_EXE_JMP;
          default:          step_d = ST_FETCH;
        endcase
      end
      ST_EXE_ALU:  step_d = ST_ALU_WB;
      ST_EXE_ADDR: step_d = (opcode_i == OP_LOAD) ? ST_LD_MEM : ST_ST_MEM;
      ST_LD_MEM:   step_d = ST_LD_WB;
      default:     step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_d;
  end

  always_comb begin
    ctl_o = '0;
    case (step_q)
      ST_FETCH: begin
        ctl_o.ir_we  = 1'b1;
        ctl_o.pc_we  = 1'b1;
        ctl_o.pc_src = PS_ALU;
        ctl_o.src_a  = SA_PC;
        ctl_o.src_b  = SB_FOUR;
        ctl_o.alu_op = ALU_ADD;
      end
      ST_DECODE: begin
        ctl_o.ab_we  = 1'b1;
        ctl_o.res_we = 1'b1;
        ctl_o.src_a  = SA_PC;
        ctl_o.src_b  = SB_BROFF;
        ctl_o.alu_op = ALU_ADD;
      end
      ST_EXE_ALU: begin
        ctl_o.res_we = 1'b1;
        ctl_o.src_a  = SA_REG;
        ctl_o.src_b  = SB_REG;
        ctl_o.alu_op = ALU_FUNCT;
      end
      ST_EXE_ADDR: begin
        ctl_o.res_we = 1'b1;
        ctl_o.src_a  = SA_REG;
        ctl_o.src_b  = SB_IMM;
        ctl_o.alu_op = ALU_ADD;
      end
      ST_EXE_BEQ: begin
        ctl_o.pc_cond = 1'b1;
        ctl_o.pc_src  = PS_LATCH;
        ctl_o.src_a   = SA_REG;
        ctl_o.src_b   = SB_REG;
        ctl_o.alu_op  = ALU_SUB;
      end
      ST_EXE_JMP: begin
        ctl_o.pc_we  = 1'b1;
        ctl_o.pc_src = PS_JUMP;
      end
      ST_ALU_WB: begin
        ctl_o.rf_we     = 1'b1;
        ctl_o.rf_dst_rd = 1'b1;
      end
      ST_LD_MEM: begin
        ctl_o.addr_from_res = 1'b1;
        ctl_o.mdr_we        = 1'b1;
      end
      ST_ST_MEM: begin
        ctl_o.addr_from_res = 1'b1;
        ctl_o.mem_we        = 1'b1;
      end
      ST_LD_WB: begin
        ctl_o.rf_we       = 1'b1;
        ctl_o.rf_from_mdr = 1'b1;
      end
      default: ;
    endcase
  end

  assign step_o = step_q;

  a_r2_decode_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_FETCH) |=> (step_q == ST_DECODE));
  a_r11_unknown_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_DECODE && !op_known(opcode_i)) |=> (step_q == ST_FETCH));
  a_r3_load_has_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_LD_MEM) |=> (step_q == ST_LD_WB));
  a_r3_short_classes_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_EXE_BEQ || step_q == ST_EXE_JMP) |=> (step_q == ST_FETCH));
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we
);
  step_e step;
  ctl_t  ctl;

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [XLEN-1:0] rs_val, rt_val, imm_sx, alu_a, alu_b, alu_y, pc_d, jump_pc, rf_wd;
  logic [REG_AW-1:0] rf_wa;
  logic alu_zero, pc_en;

  mc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .opcode_i(ir_q[31:26]),
    .step_o  (step),
    .ctl_o   (ctl)
  );

  assign rf_wa = ctl.rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = ctl.rf_from_mdr ? mdr_q : res_q;

  mc_regfile #(.W(XLEN), .N(REG_CNT)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra1_i(ir_q[25:21]),
    .ra2_i(ir_q[20:16]),
    .rd1_o(rs_val),
    .rd2_o(rt_val),
    .we_i (ctl.rf_we),
    .wa_i (rf_wa),
    .wd_i (rf_wd)
  );

  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign alu_a  = (ctl.src_a == SA_PC) ? pc_q : a_q;

  always_comb begin
    case (ctl.src_b)
      SB_REG:  alu_b = b_q;
      SB_FOUR: alu_b = XLEN'(4);
      SB_IMM:  alu_b = imm_sx;
      default: alu_b = {imm_sx[XLEN-3:0], 2'b00};
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a_i    (alu_a),
    .b_i    (alu_b),
    .op_i   (ctl.alu_op),
    .funct_i(ir_q[5:0]),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign jump_pc = {pc_q[31:28], ir_q[25:0], 2'b00};
  assign pc_en   = ctl.pc_we | (ctl.pc_cond & alu_zero);

  always_comb begin
    case (ctl.pc_src)
      PS_LATCH: pc_d = res_q;
      PS_JUMP:  pc_d = jump_pc;
      default:  pc_d = alu_y;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ir_q <= '0;
    else if (ctl.ir_we) ir_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mdr_q <= '0;
    else if (ctl.mdr_we) mdr_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ctl.ab_we) begin
      a_q <= rs_val;
      b_q <= rt_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          res_q <= '0;
    else if (ctl.res_we) res_q <= alu_y;
  end

  assign mem_addr  = ctl.addr_from_res ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl.mem_we;

  a_r2_pc_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_FETCH) |=> (pc_q == $past(pc_q) + 32'd4));
  a_r7_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXE_BEQ && a_q == b_q) |=> (pc_q == $past(res_q)));
  a_r7_branch_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXE_BEQ && a_q != b_q) |=> $stable(pc_q));
  a_r8_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXE_JMP) |=> (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28])));
  a_r11_unknown_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_DECODE && !op_known(ir_q[31:26])) |=> $stable(pc_q));
endmodule

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we;

  logic [31:0] mem  [256];
  logic [31:0] mmem [256];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int word);
    return {6'h02, 26'(word)};
  endfunction
  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] ref_alu(input logic [31:0] a, b, input logic [5:0] fn);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return {31'd0, ($signed(a) < $signed(b))};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic [31:0] ea, input logic ewe, input logic [31:0] ewd);
    chk(mem_addr === ea, req, "mem_addr", mem_addr, ea);
    chk(mem_we === ewe, req, "mem_we", {31'd0, mem_we}, {31'd0, ewe});
    if (ewe) chk(mem_wdata === ewd, req, "mem_wdata", mem_wdata, ewd);
    @(negedge clk);
  endtask

  task automatic run_instr();
    logic [31:0] ins, npc, ea, rsv, rtv;
    logic [5:0] op;
    int rs, rt, rd;
    ins = mmem[mpc[9:2]];
    op = ins[31:26];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    rsv = mreg[rs]; rtv = mreg[rt];
    npc = mpc + 32'd4;
    ea = rsv + sx(ins[15:0]);
    cyc("R2", mpc, 1'b0, 32'd0);
    cyc("R10", npc, 1'b0, 32'd0);
    case (op)
      6'h04: begin
        cyc("R7", npc, 1'b0, 32'd0);
        mpc = (rsv == rtv) ? npc + {sx(ins[15:0]), 2'b00} : npc;
      end
      6'h02: begin
        cyc("R8", npc, 1'b0, 32'd0);
        mpc = {npc[31:28], ins[25:0], 2'b00};
      end
      6'h00: begin
        cyc("R4", npc, 1'b0, 32'd0);
        cyc("R3", npc, 1'b0, 32'd0);
        if (rd != 0) mreg[rd] = ref_alu(rsv, rtv, ins[5:0]);
        mpc = npc;
      end
      6'h2B: begin
        cyc("R6", npc, 1'b0, 32'd0);
        cyc("R6", ea, 1'b1, rtv);
        mmem[ea[9:2]] = rtv;
        mpc = npc;
      end
      6'h23: begin
        cyc("R5", npc, 1'b0, 32'd0);
        cyc("R5", ea, 1'b0, 32'd0);
        cyc("R5", npc, 1'b0, 32'd0);
        if (rt != 0) mreg[rt] = mmem[ea[9:2]];
        mpc = npc;
      end
      default: mpc = npc; // R11: two cycles, nothing else changes
    endcase
  endtask

  task automatic start_run();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_addr === 32'd0 && mem_we === 1'b0, "R1", "reset bus", {mem_addr[30:0], mem_we}, 32'd0);
    for (int i = 0; i < 256; i++) mmem[i] = mem[i];
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mpc = 32'd0;
    rst_n = 1'b1;
    chk(mem_addr === 32'd0 && mem_we === 1'b0, "R1", "first fetch", mem_addr, 32'd0);
  endtask

  task automatic run_to(input logic [31:0] halt);
    int n = 0;
    while (mpc != halt && n < 3000) begin
      run_instr();
      n++;
    end
    for (int w = 128; w < 256; w++)
      chk(mem[w] === mmem[w], "R4 R5 R6 R9", $sformatf("data word %0d", w), mem[w], mmem[w]);
  endtask

  task automatic load_directed();
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    mem[128] = 32'd5; mem[129] = 32'hFFFF_FFFD; mem[130] = 32'h0000_03A0;
    mem[0]  = enc_i(6'h23, 0, 1, 16'h0200);
    mem[1]  = enc_i(6'h23, 0, 2, 16'h0204);
    mem[2]  = enc_i(6'h23, 0, 10, 16'h0208);
    mem[3]  = enc_r(1, 2, 3, 6'h20);
    mem[4]  = enc_r(1, 2, 4, 6'h22);
    mem[5]  = enc_r(1, 2, 5, 6'h24);
    mem[6]  = enc_r(1, 2, 6, 6'h25);
    mem[7]  = enc_r(1, 2, 7, 6'h2A);
    mem[8]  = enc_r(2, 1, 8, 6'h2A);
    mem[9]  = enc_r(1, 1, 9, 6'h20);
    mem[10] = enc_r(1, 1, 9, 6'h3F);
    mem[11] = enc_r(1, 1, 0, 6'h20);
    mem[12] = enc_i(6'h23, 0, 0, 16'h0200);
    mem[13] = 32'hFC00_0000;
    mem[14] = enc_i(6'h2B, 10, 3, 16'hFFFC);
    mem[15] = enc_i(6'h2B, 0, 0, 16'h0300);
    mem[16] = enc_i(6'h2B, 0, 4, 16'h0304);
    mem[17] = enc_i(6'h2B, 0, 7, 16'h0308);
    mem[18] = enc_i(6'h2B, 0, 8, 16'h030C);
    mem[19] = enc_i(6'h2B, 0, 9, 16'h0310);
    mem[20] = enc_i(6'h04, 1, 1, 16'h0001);
    mem[21] = enc_i(6'h2B, 0, 1, 16'h0314);
    mem[22] = enc_i(6'h04, 1, 2, 16'h0001);
    mem[23] = enc_i(6'h2B, 0, 2, 16'h0318);
    mem[24] = enc_j(26);
    mem[25] = enc_i(6'h2B, 0, 1, 16'h031C);
    mem[26] = enc_i(6'h2B, 0, 5, 16'h0320);
    mem[27] = enc_i(6'h2B, 0, 6, 16'h0324);
    mem[28] = enc_j(28);
  endtask

  task automatic load_random();
    int k, off, tgt;
    for (int i = 0; i < 256; i++) mem[i] = (i >= 128) ? $urandom : 32'd0;
    for (int i = 0; i < 15; i++) mem[i] = enc_i(6'h23, 0, i + 1, 16'(32'h200 + 4 * i));
    for (int i = 15; i < 90; i++) begin
      int rs = int'($urandom_range(0, 15));
      int rt = ($urandom_range(0, 2) == 0) ? rs : int'($urandom_range(0, 15));
      k = int'($urandom_range(0, 10));
      case (k)
        0, 1, 2, 3: begin
          logic [5:0] fl [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h11};
          mem[i] = enc_r(rs, rt, int'($urandom_range(0, 15)), fl[$urandom_range(0, 5)]);
        end
        4:    mem[i] = enc_i(6'h23, 0, rt, 16'(32'h200 + 4 * $urandom_range(0, 127)));
        5, 6: mem[i] = enc_i(6'h2B, 0, rt, 16'(32'h200 + 4 * $urandom_range(0, 127)));
        7, 8: begin
          off = int'($urandom_range(0, 2));
          if (i + 1 + off > 90) off = 90 - i - 1;
          mem[i] = enc_i(6'h04, rs, rt, 16'(off));
        end
        9: begin
          tgt = i + 1 + int'($urandom_range(0, 2));
          if (tgt > 90) tgt = 90;
          mem[i] = enc_j(tgt);
        end
        default: mem[i] = {6'h3F, 26'($urandom)};
      endcase
    end
    mem[90] = enc_j(90);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    @(negedge clk);
    // directed corner cases
    load_directed();
    start_run();
    run_to(32'd28 * 4);
    chk(mem[231] === 32'd2, "R4", "add result via negative offset store", mem[231], 32'd2);
    chk(mem[192] === 32'd0, "R9", "register 0 after writes", mem[192], 32'd0);
    chk(mem[193] === 32'd8, "R4", "sub result", mem[193], 32'd8);
    chk(mem[194] === 32'd0, "R4", "slt false", mem[194], 32'd0);
    chk(mem[195] === 32'd1, "R4", "slt signed true", mem[195], 32'd1);
    chk(mem[196] === 32'd0, "R4", "unknown funct gives zero", mem[196], 32'd0);
    chk(mem[197] === 32'd0, "R7", "taken branch skipped store", mem[197], 32'd0);
    chk(mem[198] === 32'hFFFF_FFFD, "R7", "untaken branch falls through", mem[198], 32'hFFFF_FFFD);
    chk(mem[199] === 32'd0, "R8", "jump skipped store", mem[199], 32'd0);
    chk(mem[200] === 32'd5, "R4", "and result", mem[200], 32'd5);
    chk(mem[201] === 32'hFFFF_FFFD, "R4", "or result", mem[201], 32'hFFFF_FFFD);
    chk(mem[128] === 32'd5, "R11", "unknown opcode left memory", mem[128], 32'd5);
    // random programs, each after a fresh reset
    for (int r = 0; r < 4; r++) begin
      load_random();
      start_run();
      run_to(32'd90 * 4);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES - 10) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule